// File: doc/BRIEF.md
# Subtract-Based Integer Compare Unit

This block compares two 64-bit integer operands and returns a 4-bit condition field holding less-than, greater-than, equal and a copied summary-overflow bit. The ordering bits do not come from a magnitude comparator. The unit forms B - A as ~A + B + 1 on a ripple carry chain. It then reads the ordering from the carry out, the sign of the difference and the operand sign bits. Equality comes from a direct test of the two operands.

A signed flag selects two's-complement or unsigned ordering. A width flag selects a comparison of the full 64 bits or of the low 32 bits only. In narrow mode the carry out of bit 31 and bit 31 of the operands and of the difference are used. The caller also supplies a destination field index, and the unit returns that index with the result.

Operands enter through a valid/ready handshake, and the result leaves through another. A transfer happens on a rising edge where valid and ready are both high. The result register holds one entry. `in_ready` is high when that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result stays unchanged and no new operands are taken.

Top module: `adder_compare`

## Requirements
- R1: The condition field is `cond[3]`=LT, `cond[2]`=GT, `cond[1]`=EQ, `cond[0]`=SO. With `is_signed`=0, LT is 1 exactly when A < B as unsigned numbers over the selected width.
- R2: When the operands are equal over the selected width, EQ is 1 and both LT and GT are 0.
- R3: With `is_signed`=1, LT is 1 exactly when A < B as two's-complement numbers over the selected width. This includes operands whose sign bits differ.
- R4: With `wide_mode`=0, only bits 31:0 of each operand take part, and bits 63:32 have no effect on LT, GT or EQ. With `wide_mode`=1, all 64 bits take part.
- R5: SO in the result equals the `sum_ovf` input sampled when the operands were accepted.
- R6: A result appears with `out_valid`=1 on the rising edge after the operands are accepted, and `cond_idx` equals the `dest_idx` that came with them. Without a new acceptance, `out_valid` falls once the result has been taken.
- R7: `in_ready` is 1 when `out_valid` is 0 or `out_ready` is 1. While `out_valid`=1 and `out_ready`=0, `cond` and `cond_idx` hold their values.
- R8: During reset, `out_valid` is 0 and `in_ready` is 1.
- R9: For every valid result, exactly one of LT, GT and EQ is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are presented |
| in_ready | output | 1 | Unit can take operands this cycle |
| opa | input | 64 | Operand A (left side of the compare) |
| opb | input | 64 | Operand B (right side of the compare) |
| is_signed | input | 1 | 1 = two's-complement ordering, 0 = unsigned |
| wide_mode | input | 1 | 1 = 64-bit compare, 0 = low 32 bits only |
| sum_ovf | input | 1 | Summary-overflow bit copied into SO |
| dest_idx | input | 3 | Destination condition field index |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| cond | output | 4 | {LT, GT, EQ, SO} |
| cond_idx | output | 3 | Destination index returned with the result |

## Verification
The hardest cases to reach come from operands whose relation depends on one exact bit. These are operands that differ only in bit 63 or only in bit 31, where signed and unsigned ordering disagree. They also include operands whose low halves match but whose upper halves differ, which must read as equal in narrow mode. Uniform random operands almost never produce these, so the stimulus chooses among several shapes: equal pairs, a single flipped sign bit, copied low halves, and extreme values such as zero and all ones. Back-pressure is tested with a directed sequence: a second operand set is offered while the output is stalled, and the first result must stay unchanged.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;
endpackage

// File: rtl/cmp_sub_chain.sv
// Forms ~a + b + 1 (b - a) bit by bit and exposes carries and sign bits
// at the narrow and full widths.
module cmp_sub_chain #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              c_narrow,
  output logic              c_full,
  output logic              s_narrow,
  output logic              s_full
);
  logic [DATA_W:0]   carry;
  logic [DATA_W-1:0] prop;
  logic [DATA_W-1:0] gen;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign prop[i]    = ~a[i] ^ b[i];
    assign gen[i]     = ~a[i] & b[i];
    assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
  end

  assign c_narrow = carry[NARROW_W];
  assign c_full   = carry[DATA_W];
  assign s_narrow = prop[NARROW_W-1] ^ carry[NARROW_W-1];
  assign s_full   = prop[DATA_W-1] ^ carry[DATA_W-1];
endmodule

// File: rtl/cmp_flag_gen.sv
// Derives the ordering bits from carry, difference sign and operand signs.
module cmp_flag_gen
  import cmp_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              c_narrow,
  input  logic              c_full,
  input  logic              s_narrow,
  input  logic              s_full,
  input  logic              is_signed,
  input  logic              wide_mode,
  input  logic              so_in,
  output cond_t             cond
);
  logic eq_sel, carry_sel, diff_sign, a_sign, b_sign, lt_raw;

  always_comb begin
    if (wide_mode) begin
      eq_sel    = (a == b);
      carry_sel = c_full;
      diff_sign = s_full;
      a_sign    = a[DATA_W-1];
      b_sign    = b[DATA_W-1];
    end else begin
      eq_sel    = (a[NARROW_W-1:0] == b[NARROW_W-1:0]);
      carry_sel = c_narrow;
      diff_sign = s_narrow;
      a_sign    = a[NARROW_W-1];
      b_sign    = b[NARROW_W-1];
    end

    if (!is_signed)          lt_raw = carry_sel;   // no borrow: b >= a
    else if (a_sign != b_sign) lt_raw = a_sign;    // negative side is smaller
    else                     lt_raw = ~diff_sign;  // same signs: b - a cannot overflow

    cond.eq = eq_sel;
    cond.lt = lt_raw & ~eq_sel;
    cond.gt = ~lt_raw & ~eq_sel;
    cond.so = so_in;
  end
endmodule

// File: rtl/cmp_out_stage.sv
// One-entry result register with valid/ready on both sides.
module cmp_out_stage
  import cmp_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  cond_t            cond_in,
  input  logic [IDX_W-1:0] idx_in,
  output logic             out_valid,
  input  logic             out_ready,
  output cond_t            cond_out,
  output logic [IDX_W-1:0] idx_out
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cond_out  <= '0;
      idx_out   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        cond_out  <= cond_in;
        idx_out   <= idx_in;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adder_compare.sv
module adder_compare
  import cmp_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              is_signed,
  input  logic              wide_mode,
  input  logic              sum_ovf,
  input  logic [IDX_W-1:0]  dest_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        cond,
  output logic [IDX_W-1:0]  cond_idx
);
  logic  c_narrow, c_full, s_narrow, s_full;
  cond_t cond_next, cond_q;

  cmp_sub_chain #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chain (
    .a(opa), .b(opb),
    .c_narrow(c_narrow), .c_full(c_full),
    .s_narrow(s_narrow), .s_full(s_full)
  );

  cmp_flag_gen #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_flags (
    .a(opa), .b(opb),
    .c_narrow(c_narrow), .c_full(c_full),
    .s_narrow(s_narrow), .s_full(s_full),
    .is_signed(is_signed), .wide_mode(wide_mode),
    .so_in(sum_ovf), .cond(cond_next)
  );

  cmp_out_stage #(.IDX_W(IDX_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .cond_in(cond_next), .idx_in(dest_idx),
    .out_valid(out_valid), .out_ready(out_ready),
    .cond_out(cond_q), .idx_out(cond_idx)
  );

  assign cond = cond_q;
endmodule

// File: rtl/adder_compare_chk.sv
module adder_compare_chk #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic              wide_mode,
  input logic              sum_ovf,
  input logic [IDX_W-1:0]  dest_idx,
  input logic              out_valid,
  input logic              out_ready,
  input logic [3:0]        cond,
  input logic [IDX_W-1:0]  cond_idx
);
  AST_ONE_ORDER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(cond[3:1]) == 1); // R9

  AST_SO_COPIED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> cond[0] == $past(sum_ovf)); // R5

  AST_IDX_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && cond_idx == $past(dest_idx))); // R6

  AST_WIDE_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && wide_mode && opa == opb) |=> cond[3:1] == 3'b001); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(cond) && $stable(cond_idx))); // R7

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready)); // R7

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R6
endmodule

bind adder_compare adder_compare_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/adder_compare_bench.sv
`timescale 1ns/1ps
module adder_compare_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] opa = '0, opb = '0;
  logic        is_signed = 1'b0, wide_mode = 1'b1, sum_ovf = 1'b0;
  logic [2:0]  dest_idx = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  cond;
  logic [2:0]  cond_idx;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  adder_compare u_adder_compare (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opa(opa), .opb(opb), .is_signed(is_signed), .wide_mode(wide_mode),
    .sum_ovf(sum_ovf), .dest_idx(dest_idx), .out_valid(out_valid),
    .out_ready(out_ready), .cond(cond), .cond_idx(cond_idx)
  );

  // Expected {LT,GT,EQ,SO} from the requirements.
  function automatic logic [3:0] ref_cond(logic [63:0] a, logic [63:0] b,
                                          logic s, logic w, logic so);
    logic lt, eq;
    if (w) begin
      eq = (a == b);
      lt = s ? ($signed(a) < $signed(b)) : (a < b);
    end else begin
      eq = (a[31:0] == b[31:0]);
      lt = s ? ($signed(a[31:0]) < $signed(b[31:0])) : (a[31:0] < b[31:0]);
    end
    return {lt, !lt && !eq, eq, so};
  endfunction

  function automatic string tag_of(logic [3:0] exp_c, logic s, logic w);
    if (exp_c[1]) return "R2";
    if (!w)       return "R4";
    if (s)        return "R3";
    return "R1";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic xfer(logic [63:0] a, logic [63:0] b, logic s, logic w,
                      logic so, logic [2:0] idx);
    logic [3:0] e;
    e = ref_cond(a, b, s, w, so);
    @(negedge clk);
    opa = a; opb = b; is_signed = s; wide_mode = w; sum_ovf = so;
    dest_idx = idx; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 valid", 32'(out_valid), 32'd1);
    check(tag_of(e, s, w), 32'(cond[3:1]), 32'(e[3:1]));
    check("R5 so", 32'(cond[0]), 32'(e[0]));
    check("R6 idx", 32'(cond_idx), 32'(idx));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] ea, eb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R8 out_valid", 32'(out_valid), 32'd0);
    check("R8 in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    // Directed corners
    xfer(64'd5, 64'd9, 1'b0, 1'b1, 1'b0, 3'd1);                          // R1 less
    xfer(64'd9, 64'd5, 1'b0, 1'b1, 1'b1, 3'd2);                          // R1 greater, R5
    xfer(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b0, 3'd3);        // R1
    xfer(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 3'd4);        // R3 sign differs
    xfer(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1, 3'd5); // R3
    xfer(64'h1234, 64'h1234, 1'b1, 1'b1, 1'b0, 3'd6);                    // R2
    xfer(64'hAAAA_0000_8000_0000, 64'h5555_0000_8000_0000, 1'b0, 1'b0, 1'b0, 3'd7); // R4 upper ignored
    xfer(64'h0000_0001_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF, 1'b1, 1'b0, 1'b1, 3'd0); // R4 signed narrow
    xfer(64'h0000_0001_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF, 1'b0, 1'b0, 1'b0, 3'd1); // R4 unsigned narrow

    // Idle: no acceptance, result drains
    @(negedge clk);
    check("R6 drain", 32'(out_valid), 32'd0);

    // Randomized shapes
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      case ($urandom % 6)
        0: ;
        1: b = a;
        2: b = a ^ 64'h8000_0000_0000_0000;
        3: b = {b[63:32], a[31:0]};
        4: b = a ^ 64'h0000_0000_8000_0000;
        default: begin a = ($urandom % 2) ? 64'h0 : 64'hFFFF_FFFF_FFFF_FFFF; b = {$urandom, $urandom}; end
      endcase
      xfer(a, b, 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
    end

    // Back-pressure sequence (R7)
    ea = ref_cond(64'd3, 64'd1, 1'b0, 1'b1, 1'b1);
    eb = ref_cond(64'hFFFF_FFFF_FFFF_FFFE, 64'd2, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    opa = 64'd3; opb = 64'd1; is_signed = 1'b0; wide_mode = 1'b1;
    sum_ovf = 1'b1; dest_idx = 3'd5; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7 valid", 32'(out_valid), 32'd1);
    check("R7 in_ready low", 32'(in_ready), 32'd0);
    opa = 64'hFFFF_FFFF_FFFF_FFFE; opb = 64'd2; is_signed = 1'b1;
    sum_ovf = 1'b0; dest_idx = 3'd2;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 hold cond", 32'(cond), 32'(ea));
      check("R7 hold idx", 32'(cond_idx), 32'd5);
      check("R7 in_ready low", 32'(in_ready), 32'd0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 next valid", 32'(out_valid), 32'd1);
    check("R7 next cond", 32'(cond), 32'(eb));
    check("R7 next idx", 32'(cond_idx), 32'd2);
    @(negedge clk);
    check("R6 drain", 32'(out_valid), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule